// File: doc/BRIEF.md
# Bus-Snooping Debug Stopwatch Counter

This is a debug cycle-timing unit. Software arms it by writing a control register. The unit then watches two data-memory address buses at the same time for an access to one programmable flag address. A write-only qualifier can restrict the match to writes. A match on either bus starts a counter, which was preloaded from two 32-bit halves, and the counter then decrements once per clock. A later write with the stop bit halts the countdown and freezes the value. Software reads the remaining count back, and elapsed cycles equal the preload minus the value read.

The counter runs either 64 bits wide or 32 bits wide, chosen at arm time. On reaching zero it holds at zero and raises a sticky underflow flag instead of wrapping. A status field reports the state: idle, armed, running or stopped. Only one counter exists, so a single measurement is in flight at a time. While it runs, further flag accesses and arm writes do not restart it.

Top module: `dbg_stopwatch`

## Requirements
- R1: After a synchronous reset the status word reads 0 (state idle, no underflow, narrow mode), the count low and high words read 0, and the qualifier register reads 1 (writes only).
- R2: Register map, on word address `reg_addr`:
  - 0 writes control and reads status.
  - 1 holds the watched address.
  - 2 holds the qualifier in bit 0.
  - 3 and 4 hold the low and high preload halves.
  - 5 and 6 read the count low and high words.
  - Control bits: bit 0 arm, bit 1 stop, bit 2 wide mode.
  - Status bits: [1:0] state (0 idle, 1 armed, 2 running, 3 stopped), bit 2 sticky underflow, bit 3 wide mode in force.
  - Read data appears one clock after the address.
- R3: A control write with arm set, made while not running, loads the count from the preload, clears underflow, latches the wide bit and enters armed. A control write without arm, made while armed, returns the unit to idle.
- R4: In the armed state, a matching access on bus 0 is sampled at edge E0. The state is running after E1. The count then drops by one at each edge from E1+1 up to and including the edge that captures the stop write. That stop edge leaves the state stopped.
- R5: A matching access on bus 1 starts the counter with exactly the same timing as one on bus 0.
- R6: With the qualifier at 1, read accesses to the watched address do not start the counter. With it at 0, they do. An access to any other address never starts it.
- R7: Matching accesses while idle have no effect, and neither do control writes without arm while idle or stopped.
- R8: Once stopped, the count and the status hold until the next arm.
- R9: While running, further matching accesses, preload writes and arm writes neither restart nor reload the counter.
- R10: A running count of zero stays at zero and sets the underflow flag. The flag stays set after the stop and clears on the next arm.
- R11: In narrow mode (wide bit 0 at arm) only the low preload is loaded. The high count word reads 0 and underflow occurs at the 32-bit level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | NBUS | Access valid, one bit per snooped bus |
| bus_write | input | NBUS | Access is a write, one bit per bus |
| bus_addr | input | NBUS*ADDR_W | Access addresses, bus i in slice i |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |

## Verification
Directed runs start the counter from each bus with short, exact gaps. These pin down the one-edge-per-cycle timing and show whether the two buses are treated alike. Read accesses under both qualifier settings, and writes to a neighbouring address, separate the qualifier and address compare from the start logic. Preloads equal to, one below and well below the gap locate the saturation boundary and the sticky flag. The same preload with a nonzero high half, run in both widths, tells the 32-bit mode from the 64-bit one. Randomized runs mix bus, width, preload and gap, with accesses and arm writes injected mid-run, and are checked against a computed saturating difference.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_ARMED = 2'd1,
    SW_RUN   = 2'd2,
    SW_STOP  = 2'd3
  } sw_state_e;

  localparam int unsigned REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] RA_WATCH = 3'd1;
  localparam logic [REG_AW-1:0] RA_QUAL  = 3'd2;
  localparam logic [REG_AW-1:0] RA_PRELO = 3'd3;
  localparam logic [REG_AW-1:0] RA_PREHI = 3'd4;
  localparam logic [REG_AW-1:0] RA_CNTLO = 3'd5;
  localparam logic [REG_AW-1:0] RA_CNTHI = 3'd6;

  localparam int unsigned CB_ARM  = 0;
  localparam int unsigned CB_STOP = 1;
  localparam int unsigned CB_WIDE = 2;
endpackage

// File: rtl/sw_addr_match.sv
module sw_addr_match #(
  parameter int unsigned NBUS   = 2,
  parameter int unsigned ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NBUS-1:0]        bus_valid,
  input  logic [NBUS-1:0]        bus_write,
  input  logic [NBUS*ADDR_W-1:0] bus_addr,
  input  logic [ADDR_W-1:0]      watch_addr,
  input  logic                   wr_only,
  output logic                   hit_q
);
  logic [NBUS-1:0] raw_hit;

  for (genvar gi = 0; gi < NBUS; gi++) begin : g_bus
    assign raw_hit[gi] = bus_valid[gi] && (bus_write[gi] || !wr_only) &&
                         (bus_addr[gi*ADDR_W +: ADDR_W] == watch_addr);
  end

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= |raw_hit;
  end

  // R6: a registered hit needs a valid access one cycle earlier
  p_hit_needs_access_r6: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> $past(|bus_valid));
  // R6: under the write-only qualifier a hit needs a write access
  p_hit_write_only_r6: assert property (@(posedge clk) disable iff (rst)
    (hit_q && $past(wr_only)) |-> $past(|(bus_valid & bus_write)));
endmodule

// File: rtl/sw_counter.sv
module sw_counter
  import sw_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ctrl_wr,
  input  logic                  ctrl_arm,
  input  logic                  ctrl_stop,
  input  logic                  ctrl_wide,
  input  logic [DATA_W-1:0]     pre_lo,
  input  logic [DATA_W-1:0]     pre_hi,
  input  logic                  hit,
  output sw_state_e             state,
  output logic [2*DATA_W-1:0]   count,
  output logic                  underflow,
  output logic                  wide_mode
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SW_IDLE;
      count     <= '0;
      underflow <= 1'b0;
      wide_mode <= 1'b0;
    end else begin
      if (state == SW_RUN) begin
        if (count != '0) count <= count - 1'b1;
        else             underflow <= 1'b1;
      end
      case (state)
        SW_RUN: begin
          if (ctrl_wr && ctrl_stop) state <= SW_STOP;
        end
        default: begin
          if (ctrl_wr && ctrl_arm) begin
            state     <= SW_ARMED;
            count     <= ctrl_wide ? {pre_hi, pre_lo} : {{DATA_W{1'b0}}, pre_lo};
            underflow <= 1'b0;
            wide_mode <= ctrl_wide;
          end else if (ctrl_wr && state == SW_ARMED) begin
            state <= SW_IDLE;
          end else if (state == SW_ARMED && hit) begin
            state <= SW_RUN;
          end
        end
      endcase
    end
  end

  // R4: one step down per running cycle
  p_step_down_r4: assert property (@(posedge clk) disable iff (rst)
    (state == SW_RUN && count != '0) |=> (count == $past(count) - 1'b1));
  // R10: zero holds and raises the sticky flag
  p_no_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (state == SW_RUN && count == '0) |=> (count == '0 && underflow));
  // R8: a stopped count is frozen until re-armed
  p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (state == SW_STOP && !(ctrl_wr && ctrl_arm)) |=> ($stable(count) && state == SW_STOP));
  // R9: running only ends through a stop write
  p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (state == SW_RUN && !(ctrl_wr && ctrl_stop)) |=> (state == SW_RUN));
  // R4: an armed hit starts the run
  p_start_r4: assert property (@(posedge clk) disable iff (rst)
    (state == SW_ARMED && hit && !ctrl_wr) |=> (state == SW_RUN));
  // R7: idle ignores everything but an arm write
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (state == SW_IDLE && !(ctrl_wr && ctrl_arm)) |=> (state == SW_IDLE));
  // R11: narrow mode keeps the upper half clear
  p_narrow_r11: assert property (@(posedge clk) disable iff (rst)
    !wide_mode |-> (count[CNT_W-1:DATA_W] == '0));
endmodule

// File: rtl/sw_regs.sv
module sw_regs
  import sw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic [REG_AW-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  input  sw_state_e             state,
  input  logic [2*DATA_W-1:0]   count,
  input  logic                  underflow,
  input  logic                  wide_mode,
  output logic                  ctrl_wr,
  output logic [ADDR_W-1:0]     watch_addr,
  output logic                  wr_only,
  output logic [DATA_W-1:0]     pre_lo,
  output logic [DATA_W-1:0]     pre_hi,
  output logic [DATA_W-1:0]     reg_rdata
);
  logic [DATA_W-1:0] watch_ext;
  logic [DATA_W-1:0] status_word;

  assign ctrl_wr = reg_wr && (reg_addr == RA_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      watch_addr <= '0;
      wr_only    <= 1'b1;
      pre_lo     <= '0;
      pre_hi     <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_WATCH: watch_addr <= reg_wdata[ADDR_W-1:0];
        RA_QUAL:  wr_only    <= reg_wdata[0];
        RA_PRELO: pre_lo     <= reg_wdata;
        RA_PREHI: pre_hi     <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    watch_ext = '0;
    watch_ext[ADDR_W-1:0] = watch_addr;
    status_word = '0;
    status_word[1:0] = state;
    status_word[2]   = underflow;
    status_word[3]   = wide_mode;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        RA_CTRL:  reg_rdata <= status_word;
        RA_WATCH: reg_rdata <= watch_ext;
        RA_QUAL:  reg_rdata <= {{(DATA_W-1){1'b0}}, wr_only};
        RA_PRELO: reg_rdata <= pre_lo;
        RA_PREHI: reg_rdata <= pre_hi;
        RA_CNTLO: reg_rdata <= count[DATA_W-1:0];
        RA_CNTHI: reg_rdata <= count[2*DATA_W-1:DATA_W];
        default:  reg_rdata <= '0;
      endcase
    end
  end

  // R2: a preload write is visible on the following read of that register
  p_prelo_readback_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == RA_PRELO && !$past(rst)) |=> (pre_lo == $past(reg_wdata)));
endmodule

// File: rtl/dbg_stopwatch.sv
module dbg_stopwatch
  import sw_pkg::*;
#(
  parameter int unsigned NBUS   = 2,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NBUS-1:0]        bus_valid,
  input  logic [NBUS-1:0]        bus_write,
  input  logic [NBUS*ADDR_W-1:0] bus_addr,
  input  logic                   reg_wr,
  input  logic [REG_AW-1:0]      reg_addr,
  input  logic [DATA_W-1:0]      reg_wdata,
  output logic [DATA_W-1:0]      reg_rdata
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  sw_state_e          state;
  logic [CNT_W-1:0]   count;
  logic               underflow;
  logic               wide_mode;
  logic               ctrl_wr;
  logic [ADDR_W-1:0]  watch_addr;
  logic               wr_only;
  logic [DATA_W-1:0]  pre_lo;
  logic [DATA_W-1:0]  pre_hi;
  logic               hit_q;

  sw_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .state(state), .count(count),
    .underflow(underflow), .wide_mode(wide_mode), .ctrl_wr(ctrl_wr),
    .watch_addr(watch_addr), .wr_only(wr_only), .pre_lo(pre_lo),
    .pre_hi(pre_hi), .reg_rdata(reg_rdata)
  );

  sw_addr_match #(.NBUS(NBUS), .ADDR_W(ADDR_W)) u_match (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .watch_addr(watch_addr), .wr_only(wr_only),
    .hit_q(hit_q)
  );

  sw_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr),
    .ctrl_arm(reg_wdata[CB_ARM]), .ctrl_stop(reg_wdata[CB_STOP]),
    .ctrl_wide(reg_wdata[CB_WIDE]), .pre_lo(pre_lo), .pre_hi(pre_hi),
    .hit(hit_q), .state(state), .count(count), .underflow(underflow),
    .wide_mode(wide_mode)
  );
endmodule

// File: tb/dbg_stopwatch_tb.sv
`timescale 1ns/1ps
module dbg_stopwatch_tb;
  localparam int NB = 2;
  localparam int AW = 32;

  logic           clk = 1'b0;
  logic           rst;
  logic [NB-1:0]  bus_valid;
  logic [NB-1:0]  bus_write;
  logic [NB*AW-1:0] bus_addr;
  logic           reg_wr;
  logic [2:0]     reg_addr;
  logic [31:0]    reg_wdata;
  logic [31:0]    reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] watch_v;

  always #2.5 clk = ~clk;

  dbg_stopwatch u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic access(input int b, input logic [31:0] ad, input logic w);
    bus_valid[b] = 1'b1; bus_write[b] = w; bus_addr[b*AW +: AW] = ad;
    @(negedge clk);
    bus_valid = '0; bus_write = '0;
  endtask

  function automatic logic [63:0] exp_count(input logic [63:0] pre, input int gap);
    return (pre >= 64'(gap)) ? pre - 64'(gap) : 64'd0;
  endfunction

  task automatic run(input int b, input logic wide, input logic [31:0] plo,
                     input logic [31:0] phi, input int gap, input logic poke,
                     input string tag);
    logic [63:0] pre;
    logic [31:0] lo, hi, st, lo2;
    logic uf;
    wr(3'd3, plo);
    wr(3'd4, phi);
    wr(3'd0, {29'd0, wide, 2'b01});
    access(b, watch_v, 1'b1);
    if (poke) begin
      access(b, watch_v, 1'b1);
      wr(3'd3, 32'h5555_5555);
      wr(3'd0, {29'd0, wide, 2'b01});
      repeat (gap - 3) @(negedge clk);
    end else begin
      repeat (gap) @(negedge clk);
    end
    wr(3'd0, 32'h2);
    pre = wide ? {phi, plo} : {32'd0, plo};
    uf  = (64'(gap) > pre);
    rd(3'd5, lo);
    rd(3'd6, hi);
    rd(3'd0, st);
    check({tag, " count"}, {hi, lo}, exp_count(pre, gap));
    check({tag, " status"}, {32'd0, st}, {60'd0, wide, uf, 2'b11});
    repeat (7) @(negedge clk);
    rd(3'd5, lo2);
    check({tag, " R8 hold"}, {32'd0, lo2}, {32'd0, lo});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    rst = 1'b1; bus_valid = '0; bus_write = '0; bus_addr = '0;
    reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd0, v); check("R1 status", {32'd0, v}, 64'd0);
    rd(3'd5, v); check("R1 cnt lo", {32'd0, v}, 64'd0);
    rd(3'd6, v); check("R1 cnt hi", {32'd0, v}, 64'd0);
    rd(3'd2, v); check("R1 qual", {32'd0, v}, 64'd1);

    // R2 register readback
    watch_v = 32'h0000_4A10;
    wr(3'd1, watch_v);
    rd(3'd1, v); check("R2 watch", {32'd0, v}, {32'd0, watch_v});
    wr(3'd3, 32'hDEAD_0001);
    rd(3'd3, v); check("R2 prelo", {32'd0, v}, 64'hDEAD_0001);

    // R7 idle ignores accesses and non-arm control writes
    access(0, watch_v, 1'b1);
    wr(3'd0, 32'h0);
    repeat (3) @(negedge clk);
    rd(3'd0, v); check("R7 idle", {32'd0, v}, 64'd0);

    // R3 arm then disarm
    wr(3'd3, 32'd1000);
    wr(3'd0, 32'h1);
    rd(3'd0, v); check("R3 armed", {32'd0, v}, 64'd1);
    rd(3'd5, v); check("R3 loaded", {32'd0, v}, 64'd1000);
    wr(3'd0, 32'h0);
    access(1, watch_v, 1'b1);
    repeat (3) @(negedge clk);
    rd(3'd0, v); check("R3 disarm", {32'd0, v}, 64'd0);

    // R6 qualifier and address compare
    wr(3'd0, 32'h1);
    access(0, watch_v, 1'b0);
    access(1, watch_v + 32'd4, 1'b1);
    repeat (3) @(negedge clk);
    rd(3'd0, v); check("R6 read/other ignored", {32'd0, v}, 64'd1);
    wr(3'd2, 32'h0);
    access(1, watch_v, 1'b0);
    repeat (2) @(negedge clk);
    rd(3'd0, v); check("R6 read starts", {32'd0, v}, 64'd2);
    wr(3'd0, 32'h2);
    rd(3'd0, v); check("R6 stopped", {32'd0, v}, 64'd3);
    wr(3'd2, 32'h1);

    // R7 control write without arm in stopped state
    wr(3'd0, 32'h0);
    rd(3'd0, v); check("R7 stop keeps", {32'd0, v}, 64'd3);

    // R4 / R5 exact timing on each bus
    run(0, 1'b0, 32'd100, 32'd0, 1, 1'b0, "R4 bus0 gap1");
    run(0, 1'b1, 32'd100, 32'd0, 13, 1'b0, "R4 bus0 gap13");
    run(1, 1'b0, 32'd100, 32'd0, 1, 1'b0, "R5 bus1 gap1");
    run(1, 1'b1, 32'd100, 32'd0, 13, 1'b0, "R5 bus1 gap13");

    // R10 saturation boundary
    run(0, 1'b0, 32'd5, 32'd0, 5, 1'b0, "R10 exact zero");
    run(1, 1'b0, 32'd5, 32'd0, 6, 1'b0, "R10 one past");
    run(0, 1'b1, 32'd2, 32'd0, 9, 1'b0, "R10 well past");
    wr(3'd0, 32'h1);
    rd(3'd0, v); check("R10 cleared on arm", {32'd0, v}, 64'd1);

    // R11 narrow versus wide with nonzero high preload
    run(0, 1'b0, 32'd3, 32'd1, 5, 1'b0, "R11 narrow");
    run(1, 1'b1, 32'd3, 32'd1, 5, 1'b0, "R11 wide");

    // R9 mid-run access, preload and arm writes
    run(0, 1'b1, 32'd40, 32'd0, 9, 1'b1, "R9 poke");
    run(1, 1'b0, 32'd40, 32'd7, 4, 1'b1, "R9 poke narrow");

    // random runs
    for (int i = 0; i < 24; i++) begin
      int b, gap;
      logic wide;
      logic [31:0] plo, phi;
      watch_v = $urandom;
      wr(3'd1, watch_v);
      b = int'($urandom % 2);
      wide = 1'($urandom % 2);
      plo = $urandom % 60;
      phi = ($urandom % 3 == 0) ? $urandom : 32'd0;
      gap = 3 + int'($urandom % 60);
      run(b, wide, plo, phi, gap, 1'($urandom % 2), "R4 R9 R10 R11 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule